// File: doc/BRIEF.md
# Security-Banked Processor Control Register

This block holds a processor's control register. The register has a Secure copy and a Non-secure copy. Software reads and writes it through a special-register move port. The request carries:

- a register number
- the caller's security state
- the caller's privilege level
- whether the core is in handler or thread mode

The block decodes two register numbers. One is an alias that selects the bank of the current security state. The other reaches the Non-secure bank from Secure code.

Four fields are implemented: an unprivileged-thread flag, a stack-select flag, a floating-point-context-active flag and a secure-floating-point-active flag. The two stack and privilege flags exist once per security state. The two floating-point flags exist only once, in the Secure copy, and are merged into the Non-secure views on read.

Each write is filtered by several inputs: security state, privilege, handler mode, a grant bit that lets Non-secure code reach coprocessor 10, and three build parameters. The parameters select whether a floating-point unit is present, whether the security extension is present, and v8 versus v7 behaviour.

Top module: `ctrl_sec_bank`

## Requirements
- R1: Field positions in read and write data are: bit 0 unprivileged-thread, bit 1 stack-select, bit 2 FP-context-active, bit 3 secure-FP-active. All other read bits are zero. Reset clears both copies and both FP flags.
- R2: A read of number 0x14 from Secure state returns the Secure copy together with both FP flags.
- R3: A read of number 0x14 from Non-secure state returns the Non-secure copy with FP-context-active merged in, and secure-FP-active reads as zero.
- R4: A read of number 0x94 returns zero from Non-secure state. From Secure state it returns the Non-secure copy with FP-context-active merged in.
- R5: An unprivileged write changes only secure-FP-active. Its effect on the other three fields, and any unprivileged write to 0x94, is ignored.
- R6: secure-FP-active is written only from Secure state, with a floating-point unit present. Non-secure writes to it are ignored.
- R7: A write to 0x14 updates FP-context-active only when three things hold: the write is privileged, a floating-point unit is present, and at least one of these is true — the caller is Secure, the security extension is absent, or the coprocessor-10 grant is 1.
- R8: A privileged Secure write to 0x94 sets the Non-secure copy's two flags. It updates FP-context-active only if a floating-point unit is present and the coprocessor-10 grant is 1. A write to 0x94 from Non-secure state is ignored.
- R9: A privileged write updates stack-select when the v8 parameter is set or the core is in thread mode. Under v7 rules, a handler-mode write leaves stack-select unchanged.
- R10: Without a floating-point unit, both FP flags always read as zero.
- R11: Without the security extension, every access uses the Non-secure copy, and 0x94 is not decoded (reads zero, writes ignored).
- R12: Writes to any other register number change nothing, and reads of other numbers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_i | input | 1 | Caller is in Secure state |
| priv_i | input | 1 | Caller is privileged |
| handler_i | input | 1 | Core is in handler mode |
| cp10_ns_i | input | 1 | Non-secure coprocessor-10 access grant |
| wr_en_i | input | 1 | Write strobe, committed on the rising clock edge |
| reg_num_i | input | NUM_W | Special-register number |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Combinational read data |

## Verification
Some properties hold on every cycle, and the embedded assertions check these continuously:

- the Non-secure views never expose secure-FP-active;
- the Non-secure alias reads zero from Non-secure state;
- unprivileged and Non-secure writes leave their protected fields untouched;
- v7 handler-mode writes keep stack-select unchanged;
- a build without an FPU keeps both FP flags at zero.

Other behaviour can only be shown by the bench's scripted scenarios. These include the merge of the shared FP-context flag into both Non-secure views, and the coprocessor-10 gating on each alias. They also cover the state left behind by a sequence of writes from different security states, and the reduced variant without an FPU and without the security extension.

// File: rtl/ctrl_sec_bank.sv
module ctrl_sec_bank #(
  parameter bit HAS_FPU = 1'b1,
  parameter bit HAS_SEC = 1'b1,
  parameter bit IS_V8   = 1'b1,
  parameter int NUM_W   = 8,
  parameter int DATA_W  = 32,
  parameter logic [NUM_W-1:0] CUR_NUM = 8'h14,
  parameter logic [NUM_W-1:0] NSA_NUM = 8'h94
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_i,
  input  logic              priv_i,
  input  logic              handler_i,
  input  logic              cp10_ns_i,
  input  logic              wr_en_i,
  input  logic [NUM_W-1:0]  reg_num_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int B_NPRIV = 0;
  localparam int B_SPSEL = 1;
  localparam int B_FPCA  = 2;
  localparam int B_SFPA  = 3;

  logic s_npriv, s_spsel, ns_npriv, ns_spsel, fp_ctx, fp_sec;

  logic sec, hit_cur, hit_nsa, wr_cur, wr_nsa, spsel_ok, fpca_cur_ok;

  assign sec         = HAS_SEC && sec_i;
  assign hit_cur     = reg_num_i == CUR_NUM;
  assign hit_nsa     = HAS_SEC && (reg_num_i == NSA_NUM);
  assign wr_cur      = wr_en_i && hit_cur;
  assign wr_nsa      = wr_en_i && hit_nsa && sec && priv_i;
  assign spsel_ok    = priv_i && (IS_V8 || !handler_i);
  assign fpca_cur_ok = priv_i && HAS_FPU && (sec || !HAS_SEC || cp10_ns_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_npriv  <= 1'b0;
      s_spsel  <= 1'b0;
      ns_npriv <= 1'b0;
      ns_spsel <= 1'b0;
      fp_ctx   <= 1'b0;
      fp_sec   <= 1'b0;
    end else if (wr_cur) begin
      if (priv_i) begin
        if (sec) s_npriv  <= wr_data_i[B_NPRIV];
        else     ns_npriv <= wr_data_i[B_NPRIV];
      end
      if (spsel_ok) begin
        if (sec) s_spsel  <= wr_data_i[B_SPSEL];
        else     ns_spsel <= wr_data_i[B_SPSEL];
      end
      if (HAS_FPU && sec) fp_sec <= wr_data_i[B_SFPA];
      if (fpca_cur_ok)    fp_ctx <= wr_data_i[B_FPCA];
    end else if (wr_nsa) begin
      ns_npriv <= wr_data_i[B_NPRIV];
      ns_spsel <= wr_data_i[B_SPSEL];
      if (HAS_FPU && cp10_ns_i) fp_ctx <= wr_data_i[B_FPCA];
    end
  end

  logic ctx_v, sfp_v;
  assign ctx_v = HAS_FPU && fp_ctx;
  assign sfp_v = HAS_FPU && fp_sec;

  always_comb begin
    rd_data_o = '0;
    if (hit_cur) begin
      rd_data_o[B_FPCA] = ctx_v;
      if (sec) begin
        rd_data_o[B_NPRIV] = s_npriv;
        rd_data_o[B_SPSEL] = s_spsel;
        rd_data_o[B_SFPA]  = sfp_v;
      end else begin
        rd_data_o[B_NPRIV] = ns_npriv;
        rd_data_o[B_SPSEL] = ns_spsel;
      end
    end else if (hit_nsa && sec) begin
      rd_data_o[B_NPRIV] = ns_npriv;
      rd_data_o[B_SPSEL] = ns_spsel;
      rd_data_o[B_FPCA]  = ctx_v;
    end
  end

  a_r3_ns_hides_sfpa: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec && hit_cur) |-> !rd_data_o[B_SFPA]);

  a_r4_nsa_zero_from_ns: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec && hit_nsa) |-> (rd_data_o == '0));

  a_r5_unpriv_keeps_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !priv_i) |=> ($stable(s_npriv) && $stable(ns_npriv) &&
                              $stable(s_spsel) && $stable(ns_spsel) && $stable(fp_ctx)));

  a_r6_ns_keeps_sfpa: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !sec) |=> $stable(fp_sec));

  a_r9_v7_handler_spsel: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_V8 && wr_en_i && handler_i) |=> ($stable(s_spsel) && $stable(ns_spsel)));

  a_r10_nofpu_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_FPU |-> (rd_data_o[B_FPCA] == 1'b0 && rd_data_o[B_SFPA] == 1'b0));

  a_r12_other_num_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_cur && !hit_nsa) |-> (rd_data_o == '0));
endmodule

// File: tb/ctrl_sec_bank_bench.sv
`timescale 1ns/1ps
module ctrl_sec_bank_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sec, priv, hdl, cp10, wr_en;
  logic [7:0]  num;
  logic [31:0] wdata, rdata;
  logic sec2, priv2, hdl2, cp102, wr2;
  logic [7:0]  num2;
  logic [31:0] wdata2, rdata2;

  ctrl_sec_bank u_ctrl_sec_bank (
    .clk(clk), .rst_n(rst_n), .sec_i(sec), .priv_i(priv), .handler_i(hdl),
    .cp10_ns_i(cp10), .wr_en_i(wr_en), .reg_num_i(num), .wr_data_i(wdata),
    .rd_data_o(rdata));

  ctrl_sec_bank #(.HAS_FPU(1'b0), .HAS_SEC(1'b0), .IS_V8(1'b0)) u_ctrl_sec_bank_lite (
    .clk(clk), .rst_n(rst_n), .sec_i(sec2), .priv_i(priv2), .handler_i(hdl2),
    .cp10_ns_i(cp102), .wr_en_i(wr2), .reg_num_i(num2), .wr_data_i(wdata2),
    .rd_data_o(rdata2));

  int n_chk = 0;
  int n_bad = 0;

  // fields: wen wsec wpriv whdl wcp10 wnum[8] wdata[4] rsec rnum[8] exp[4]
  localparam int NV = 18;
  localparam logic [29:0] VT [NV] = '{
    {1'b1,1'b1,1'b1,1'b0,1'b0,8'h14,4'hF, 1'b1,8'h14,4'hF},
    {1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0, 1'b0,8'h14,4'h4},
    {1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0, 1'b0,8'h94,4'h0},
    {1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0, 1'b1,8'h94,4'h4},
    {1'b1,1'b0,1'b1,1'b0,1'b0,8'h14,4'hB, 1'b0,8'h14,4'h7},
    {1'b1,1'b0,1'b1,1'b0,1'b1,8'h14,4'h0, 1'b0,8'h14,4'h0},
    {1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0, 1'b1,8'h14,4'hB},
    {1'b1,1'b1,1'b0,1'b0,1'b0,8'h14,4'h0, 1'b1,8'h14,4'h3},
    {1'b1,1'b1,1'b0,1'b0,1'b1,8'h14,4'hF, 1'b1,8'h14,4'hB},
    {1'b1,1'b0,1'b0,1'b0,1'b1,8'h14,4'hF, 1'b0,8'h14,4'h0},
    {1'b1,1'b1,1'b0,1'b0,1'b1,8'h94,4'hF, 1'b1,8'h94,4'h0},
    {1'b1,1'b1,1'b1,1'b0,1'b0,8'h94,4'hF, 1'b1,8'h94,4'h3},
    {1'b1,1'b1,1'b1,1'b0,1'b1,8'h94,4'h4, 1'b1,8'h94,4'h4},
    {1'b1,1'b0,1'b1,1'b0,1'b1,8'h94,4'hF, 1'b1,8'h94,4'h4},
    {1'b1,1'b1,1'b1,1'b0,1'b1,8'h15,4'h0, 1'b1,8'h14,4'hF},
    {1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'h0, 1'b1,8'h15,4'h0},
    {1'b1,1'b1,1'b1,1'b1,1'b1,8'h14,4'h0, 1'b1,8'h14,4'h0},
    {1'b1,1'b1,1'b1,1'b0,1'b0,8'h14,4'h4, 1'b1,8'h14,4'h4}
  };

  function automatic string req_of(int i);
    case (i)
      0, 6:      return "R2";
      1, 4:      return "R3";
      2, 3:      return "R4";
      5:         return "R7";
      7, 8:      return "R5";
      9:         return "R6";
      10, 11, 12, 13: return "R8";
      14, 15:    return "R12";
      16:        return "R9";
      default:   return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle1();
    wr_en = 1'b0; wr2 = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec = 1'b1; priv = 1'b1; hdl = 1'b0; cp10 = 1'b0;
    wr_en = 1'b0; num = 8'h14; wdata = '0;
    sec2 = 1'b0; priv2 = 1'b1; hdl2 = 1'b0; cp102 = 1'b0; wr2 = 1'b0;
    num2 = 8'h14; wdata2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 reset secure view", rdata, 32'h0);
    sec = 1'b0;
    #1 check("R1 reset ns view", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VT[i][29]; sec = VT[i][28]; priv = VT[i][27]; hdl = VT[i][26];
      cp10 = VT[i][25]; num = VT[i][24:17]; wdata = {28'h0, VT[i][16:13]};
      @(negedge clk);
      wr_en = 1'b0; sec = VT[i][12]; num = VT[i][11:4];
      wdata = 32'hFFFF_FFF0;
      #1 check(req_of(i), rdata, {28'h0, VT[i][3:0]});
    end

    // R1: upper bits of write data never appear
    @(negedge clk);
    wr_en = 1'b1; sec = 1'b1; priv = 1'b1; hdl = 1'b0; num = 8'h14; wdata = 32'hFFFF_FFF0;
    @(negedge clk); idle1();
    #1 check("R1 upper bits zero", rdata, 32'h0);

    // R1: reset clears both banks mid-run
    @(negedge clk);
    wr_en = 1'b1; sec = 1'b1; cp10 = 1'b1; num = 8'h94; wdata = 32'h7;
    @(negedge clk); idle1(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; sec = 1'b1; num = 8'h94;
    #1 check("R1 reset ns bank", rdata, 32'h0);

    // lite variant: no FPU, no security extension, v7 rules
    @(negedge clk);
    wr2 = 1'b1; sec2 = 1'b1; priv2 = 1'b1; hdl2 = 1'b0; num2 = 8'h14; wdata2 = 32'hF;
    @(negedge clk); idle1();
    #1 check("R10 no fpu flags zero", rdata2, 32'h3);
    @(negedge clk);
    wr2 = 1'b1; hdl2 = 1'b1; wdata2 = 32'h0;
    @(negedge clk); idle1(); hdl2 = 1'b0;
    #1 check("R9 v7 handler keeps spsel", rdata2, 32'h2);
    sec2 = 1'b0;
    #1 check("R11 one bank regardless of sec", rdata2, 32'h2);
    @(negedge clk);
    wr2 = 1'b1; sec2 = 1'b1; num2 = 8'h94; wdata2 = 32'h3;
    @(negedge clk); idle1();
    #1 check("R11 ns alias undecoded read", rdata2, 32'h0);
    num2 = 8'h14;
    #1 check("R11 ns alias write ignored", rdata2, 32'h2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule